// File: doc/BRIEF.md
# Multi-channel UTOPIA transmit cell port

This block is the transmit side of a four-channel physical-layer device as seen from the ATM layer. It behaves as a UTOPIA Level 2 slave on an 8-bit bus clocked by the ATM layer. The ATM layer polls the channels by address to learn which ones can take a cell, selects one, and then streams a 53-byte cell into it. Each channel owns a cell FIFO, and every FIFO carries complete cells across to an independent device clock. On the device-clock side, each channel has its own byte-wide read port.

The write side runs entirely on the interface clock. Each channel tracks its own position within the current cell, so a transfer may pause, let the ATM layer poll other channels, and then resume. Start-of-cell marking is checked. A cell that is cut off by a new start marker is dropped, and so is a cell that arrives when no room is left. Both events raise a sticky error flag for that channel. Occupancy crosses between the clock domains as Gray-coded cell pointers, so the read side only ever sees whole cells.

Top module: `utx_port`

## Requirements
- R1: One interface clock after an address is presented, utp_clav reflects that address. It is high only if the address belongs to a channel whose FIFO can take one more complete 53-byte cell, counting a cell already in progress on that channel. It is low for an address that belongs to no channel.
- R2: Channel i answers to address BASE_ADDR+i. With the default BASE_ADDR of 0, channels 0 to 3 use addresses 0 to 3.
- R3: The target of a transfer is the address present in the most recent interface cycle in which utp_enb_n was high. Bytes are taken only in cycles where utp_enb_n is low. If the selected address belongs to no channel, bytes are ignored and no channel changes.
- R4: A cell is 53 bytes, and its first byte is marked by utp_soc high. It is delivered on its own channel's read port in byte order, and rd_sof is high for byte 0 only.
- R5: If utp_soc arrives while a cell is partly written on that channel, the partial cell is discarded, err_flag for that channel goes high and stays high until reset, and the new cell is accepted normally.
- R6: A byte that arrives with utp_soc low while no cell is in progress on the selected channel is ignored and does not raise err_flag.
- R7: Each channel FIFO holds 4 cells. When it is full, polling that channel returns utp_clav low. A cell started anyway is dropped whole and raises that channel's err_flag.
- R8: rd_rdy for a channel rises only after all 53 bytes of a cell have been written. A transfer that pauses mid-cell and later resumes still yields one intact cell.
- R9: A read channel delivers cells in write order. rd_pop has no effect while rd_rdy is low, and the channels are independent of each other.
- R10: After reset, utp_clav, err_flag and rd_rdy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Interface clock supplied by the ATM layer |
| tx_rst_n | input | 1 | Active-low reset, interface domain |
| utp_addr | input | 5 | Poll / select address |
| utp_enb_n | input | 1 | Active-low byte enable from the ATM layer |
| utp_soc | input | 1 | Marks byte 0 of a cell |
| utp_data | input | 8 | Cell byte |
| utp_clav | output | 1 | Cell-available answer to the last polled address |
| err_flag | output | 4 | Sticky per-channel framing/overflow error |
| dev_clk | input | 1 | Device clock, read side |
| dev_rst_n | input | 1 | Active-low reset, device domain |
| rd_pop | input | 4 | Per-channel byte consume strobe |
| rd_rdy | output | 4 | Per-channel: at least one whole cell stored |
| rd_sof | output | 4 | Per-channel: head byte is byte 0 of a cell |
| rd_data | output | 32 | Per-channel head byte, channel i in bits 8i+7:8i |

## Verification
The bench pauses a cell after 30 bytes and waits well beyond the synchronizer latency. A design that published bytes or pointers before a cell was complete would raise rd_rdy too early, and one that lost its place on resume would deliver a corrupted cell. The bench also truncates a cell with a fresh start marker and overfills a channel to five cells. A design that kept the stale bytes, or wrapped its pointers, would then show a wrong cell, a missing flag, or a lost cell at the head of the read port. Stray bytes without a start marker, a selection of an address outside the channel range, and pops on an empty channel are each followed by a clean cell. This exposes designs that merge garbage into the stream or move a pointer they should have left alone.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef logic [7:0] byte_t;

    function automatic logic [7:0] bin2gray8(logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [7:0] gray2bin8(logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/utx_sync.sv
module utx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = din;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.stab;
endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
    import utx_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = 6,
    parameter int PW         = 3
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_idx,
    input  byte_t            wr_data,
    input  logic             wr_commit,
    output logic [PW-1:0]    wr_count,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_pop,
    output byte_t            rd_data,
    output logic             rd_sof,
    output logic             rd_rdy
);
    localparam int SLOT_W = PW - 1;
    localparam int MEM_N  = DEPTH * CELL_BYTES;
    localparam int MA_W   = $clog2(MEM_N);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wptr_t;

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic [CNT_W-1:0] idx;
    } rptr_t;

    wptr_t w_d, w_q;
    rptr_t r_d, r_q;

    byte_t mem [MEM_N];

    logic [PW-1:0] rgray_s, wgray_s;
    logic [PW-1:0] rbin_s, wbin_s;
    logic [PW-1:0] rd_count;
    logic [MA_W-1:0] waddr, raddr;

    // pointer synchronizers, one per direction
    utx_sync #(.W(PW)) u_rsync (.clk(wr_clk), .rst_n(wr_rst_n), .din(r_q.gray), .dout(rgray_s));
    utx_sync #(.W(PW)) u_wsync (.clk(rd_clk), .rst_n(rd_rst_n), .din(w_q.gray), .dout(wgray_s));

    assign rbin_s = PW'(gray2bin8(8'(rgray_s)));
    assign wbin_s = PW'(gray2bin8(8'(wgray_s)));

    // ---------------- write domain ----------------
    assign wr_count = w_q.bin - rbin_s;
    assign waddr    = MA_W'(w_q.bin[SLOT_W-1:0]) * MA_W'(CELL_BYTES) + MA_W'(wr_idx);

    always_comb begin
        w_d = w_q;
        if (wr_commit) begin
            w_d.bin  = w_q.bin + PW'(1);
            w_d.gray = PW'(bin2gray8(8'(w_d.bin)));
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) w_q <= '0;
        else           w_q <= w_d;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[waddr] <= wr_data;
    end

    // ---------------- read domain ----------------
    assign rd_count = wbin_s - r_q.bin;
    assign rd_rdy   = (rd_count != '0);
    assign rd_sof   = rd_rdy && (r_q.idx == '0);
    assign raddr    = MA_W'(r_q.bin[SLOT_W-1:0]) * MA_W'(CELL_BYTES) + MA_W'(r_q.idx);
    assign rd_data  = mem[raddr];

    always_comb begin
        r_d = r_q;
        if (rd_pop && rd_rdy) begin
            if (r_q.idx == CNT_W'(CELL_BYTES - 1)) begin
                r_d.idx  = '0;
                r_d.bin  = r_q.bin + PW'(1);
                r_d.gray = PW'(bin2gray8(8'(r_d.bin)));
            end else begin
                r_d.idx = r_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) r_q <= '0;
        else           r_q <= r_d;
    end

    // ---------------- assertions ----------------
    // R7: a cell is never committed into a full FIFO
    p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_commit |-> (int'(wr_count) < DEPTH));

    // R4: a commit always coincides with the last byte of the cell
    p_commit_last_byte_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_commit |-> (wr_en && wr_idx == CNT_W'(CELL_BYTES - 1)));

    // R8: the synchronized write pointer moves by at most one Gray step
    p_gray_step_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(wgray_s ^ $past(wgray_s)) <= 1);

    // R9: the read side never sees more cells than the FIFO holds
    p_count_bound_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        int'(rd_count) <= DEPTH);
endmodule

// File: rtl/utx_slave.sv
module utx_slave
    import utx_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 5,
    parameter int BASE_ADDR  = 0,
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4,
    parameter int PW         = 3,
    parameter int CNT_W      = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       enb_n,
    input  logic                       soc,
    input  byte_t                      data,
    output logic                       clav,
    output logic [NUM_CH-1:0]          err,
    input  logic [NUM_CH-1:0][PW-1:0]  fifo_count,
    output logic [NUM_CH-1:0]          wr_en,
    output logic [CNT_W-1:0]           wr_idx,
    output byte_t                      wr_data,
    output logic [NUM_CH-1:0]          wr_commit
);
    localparam int CH_W = $clog2(NUM_CH);

    typedef struct packed {
        logic              enb_n;
        logic              soc;
        byte_t             data;
        logic [ADDR_W-1:0] addr;
    } in_t;

    typedef struct packed {
        in_t                          in;
        logic                         clav;
        logic                         sel_vld;
        logic [CH_W-1:0]              sel_ch;
        logic [NUM_CH-1:0]            act;
        logic [NUM_CH-1:0]            drop;
        logic [NUM_CH-1:0]            err;
        logic [NUM_CH-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t d, q;

    logic [ADDR_W-1:0] raw_off, q_off;
    logic              raw_hit, q_hit;
    logic [NUM_CH-1:0] room;
    logic [CH_W-1:0]   c;

    assign raw_off = addr - ADDR_W'(BASE_ADDR);
    assign raw_hit = raw_off < ADDR_W'(NUM_CH);
    assign q_off   = q.in.addr - ADDR_W'(BASE_ADDR);
    assign q_hit   = q_off < ADDR_W'(NUM_CH);
    assign c       = q.sel_ch;

    // room for one more whole cell, counting a cell in progress
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            room[i] = (int'(fifo_count[i]) + int'(q.act[i] && !q.drop[i])) < DEPTH;
        end
    end

    always_comb begin
        d          = q;
        d.in.enb_n = enb_n;
        d.in.soc   = soc;
        d.in.data  = data;
        d.in.addr  = addr;
        d.clav     = raw_hit && room[raw_off[CH_W-1:0]];

        wr_en     = '0;
        wr_commit = '0;
        wr_idx    = '0;
        wr_data   = q.in.data;

        if (q.in.enb_n) begin
            d.sel_vld = q_hit;
            d.sel_ch  = q_off[CH_W-1:0];
        end else if (q.sel_vld) begin
            if (q.in.soc) begin
                if (q.act[c]) d.err[c] = 1'b1;
                d.act[c] = 1'b1;
                d.cnt[c] = CNT_W'(1);
                if (int'(fifo_count[c]) < DEPTH) begin
                    d.drop[c] = 1'b0;
                    wr_en[c]  = 1'b1;
                end else begin
                    d.drop[c] = 1'b1;
                    d.err[c]  = 1'b1;
                end
            end else if (q.act[c]) begin
                wr_idx   = q.cnt[c];
                wr_en[c] = !q.drop[c];
                if (q.cnt[c] == CNT_W'(CELL_BYTES - 1)) begin
                    d.act[c]     = 1'b0;
                    wr_commit[c] = !q.drop[c];
                end else begin
                    d.cnt[c] = q.cnt[c] + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.in.enb_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clav = q.clav;
    assign err  = q.err;

    // R5: error flags are sticky until reset
    for (genvar g = 0; g < NUM_CH; g++) begin : g_err_chk
        p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(q.err[g]) |-> q.err[g]);
    end
endmodule

// File: rtl/utx_port.sv
module utx_port
    import utx_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 5,
    parameter int BASE_ADDR  = 0,
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4
) (
    input  logic                  tx_clk,
    input  logic                  tx_rst_n,
    input  logic [ADDR_W-1:0]     utp_addr,
    input  logic                  utp_enb_n,
    input  logic                  utp_soc,
    input  logic [7:0]            utp_data,
    output logic                  utp_clav,
    output logic [NUM_CH-1:0]     err_flag,
    input  logic                  dev_clk,
    input  logic                  dev_rst_n,
    input  logic [NUM_CH-1:0]     rd_pop,
    output logic [NUM_CH-1:0]     rd_rdy,
    output logic [NUM_CH-1:0]     rd_sof,
    output logic [NUM_CH*8-1:0]   rd_data
);
    localparam int PW    = $clog2(DEPTH) + 1;
    localparam int CNT_W = $clog2(CELL_BYTES + 1);

    logic [NUM_CH-1:0][PW-1:0] fifo_count;
    logic [NUM_CH-1:0]         wr_en;
    logic [NUM_CH-1:0]         wr_commit;
    logic [CNT_W-1:0]          wr_idx;
    byte_t                     wr_data;

    utx_slave #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH), .PW(PW), .CNT_W(CNT_W)
    ) u_slave (
        .clk(tx_clk), .rst_n(tx_rst_n),
        .addr(utp_addr), .enb_n(utp_enb_n), .soc(utp_soc), .data(utp_data),
        .clav(utp_clav), .err(err_flag),
        .fifo_count(fifo_count),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        utx_cell_fifo #(
            .DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES), .CNT_W(CNT_W), .PW(PW)
        ) u_fifo (
            .wr_clk(tx_clk), .wr_rst_n(tx_rst_n),
            .wr_en(wr_en[g]), .wr_idx(wr_idx), .wr_data(wr_data),
            .wr_commit(wr_commit[g]), .wr_count(fifo_count[g]),
            .rd_clk(dev_clk), .rd_rst_n(dev_rst_n),
            .rd_pop(rd_pop[g]), .rd_data(rd_data[g*8 +: 8]),
            .rd_sof(rd_sof[g]), .rd_rdy(rd_rdy[g])
        );
    end
endmodule

// File: tb/utx_port_tb.sv
module utx_port_tb_top;
    logic       tx_clk = 1'b0;
    logic       dev_clk = 1'b0;
    logic       tx_rst_n = 1'b0;
    logic       dev_rst_n = 1'b0;
    logic [4:0] utp_addr = 5'h1F;
    logic       utp_enb_n = 1'b1;
    logic       utp_soc = 1'b0;
    logic [7:0] utp_data = 8'h00;
    logic       utp_clav;
    logic [3:0] err_flag;
    logic [3:0] rd_pop = 4'h0;
    logic [3:0] rd_rdy;
    logic [3:0] rd_sof;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 tx_clk = ~tx_clk;
    always #3 dev_clk = ~dev_clk;

    utx_port dut_i (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
        .utp_addr(utp_addr), .utp_enb_n(utp_enb_n), .utp_soc(utp_soc), .utp_data(utp_data),
        .utp_clav(utp_clav), .err_flag(err_flag),
        .dev_clk(dev_clk), .dev_rst_n(dev_rst_n),
        .rd_pop(rd_pop), .rd_rdy(rd_rdy), .rd_sof(rd_sof), .rd_data(rd_data)
    );

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 29 + k * 7 + 3) & 255);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_dev(int n);
        repeat (n) @(negedge dev_clk);
    endtask

    task automatic sel(logic [4:0] a);
        @(negedge tx_clk);
        utp_enb_n = 1'b1; utp_soc = 1'b0; utp_addr = a;
    endtask

    task automatic idle();
        @(negedge tx_clk);
        utp_enb_n = 1'b1; utp_soc = 1'b0; utp_addr = 5'h1F;
    endtask

    task automatic send(logic [4:0] a, int seed, int first, int last, bit with_soc);
        sel(a);
        for (int k = first; k <= last; k++) begin
            @(negedge tx_clk);
            utp_enb_n = 1'b0;
            utp_soc   = with_soc && (k == first);
            utp_data  = pat(seed, k);
        end
        idle();
    endtask

    task automatic poll(logic [4:0] a, output logic cl);
        sel(a);
        @(negedge tx_clk);
        cl = utp_clav;
    endtask

    task automatic read_cell(int ch, int seed, string req);
        int  bad = 0;
        int  act = 0;
        int  exp = 0;
        for (int k = 0; k < 53; k++) begin
            @(negedge dev_clk);
            if (!rd_rdy[ch] || rd_sof[ch] != (k == 0) || rd_data[ch*8 +: 8] != pat(seed, k)) begin
                if (bad == 0) begin
                    act = {rd_rdy[ch], rd_sof[ch], rd_data[ch*8 +: 8]};
                    exp = {1'b1, (k == 0), pat(seed, k)};
                end
                bad++;
            end
            rd_pop[ch] = 1'b1;
        end
        @(negedge dev_clk);
        rd_pop[ch] = 1'b0;
        check(bad == 0, req, act, exp);
    endtask

    // R10
    task automatic t_reset();
        check(utp_clav == 1'b0, "R10 clav", utp_clav, 0);
        check(err_flag == 4'h0, "R10 err", err_flag, 0);
        check(rd_rdy == 4'h0, "R10 rdy", rd_rdy, 0);
    endtask

    // R1 R2
    task automatic t_poll();
        logic cl;
        for (int a = 0; a < 4; a++) begin
            poll(5'(a), cl);
            check(cl == 1'b1, "R1 R2 empty channel clav", cl, 1);
        end
        poll(5'd10, cl);
        check(cl == 1'b0, "R1 unmatched clav", cl, 0);
        idle();
    endtask

    // R4 R3 R9
    task automatic t_basic();
        send(5'd2, 11, 0, 52, 1'b1);
        wait_dev(10);
        check(rd_rdy == 4'b0100, "R3 R9 only ch2 ready", rd_rdy, 4'b0100);
        read_cell(2, 11, "R4 cell ch2");
        wait_dev(2);
        check(rd_rdy[2] == 1'b0, "R9 ch2 empty after read", rd_rdy[2], 0);
    endtask

    // R3: unmatched selection
    task automatic t_unmatched();
        send(5'd9, 12, 0, 52, 1'b1);
        wait_dev(10);
        check(rd_rdy == 4'h0, "R3 unmatched ignored rdy", rd_rdy, 0);
        check(err_flag == 4'h0, "R3 unmatched ignored err", err_flag, 0);
    endtask

    // R6
    task automatic t_stray();
        send(5'd3, 13, 0, 9, 1'b0);
        wait_dev(10);
        check(rd_rdy[3] == 1'b0, "R6 stray bytes no cell", rd_rdy[3], 0);
        check(err_flag[3] == 1'b0, "R6 stray bytes no err", err_flag[3], 0);
        send(5'd3, 14, 0, 52, 1'b1);
        wait_dev(10);
        read_cell(3, 14, "R6 clean cell after stray");
    endtask

    // R8
    task automatic t_partial();
        send(5'd1, 15, 0, 29, 1'b1);
        wait_dev(15);
        check(rd_rdy[1] == 1'b0, "R8 partial cell hidden", rd_rdy[1], 0);
        send(5'd1, 15, 30, 52, 1'b0);
        wait_dev(10);
        check(rd_rdy[1] == 1'b1, "R8 resumed cell visible", rd_rdy[1], 1);
        check(err_flag[1] == 1'b0, "R8 pause not error", err_flag[1], 0);
        read_cell(1, 15, "R8 resumed cell intact");
    endtask

    // R9: pop while empty
    task automatic t_pop_empty();
        @(negedge dev_clk); rd_pop[2] = 1'b1;
        wait_dev(3);
        rd_pop[2] = 1'b0;
        send(5'd2, 16, 0, 52, 1'b1);
        wait_dev(10);
        read_cell(2, 16, "R9 pop on empty ignored");
    endtask

    // R5
    task automatic t_mid_soc();
        send(5'd0, 17, 0, 19, 1'b1);
        send(5'd0, 18, 0, 52, 1'b1);
        wait_dev(10);
        check(err_flag == 4'b0001, "R5 err on ch0 only", err_flag, 4'b0001);
        read_cell(0, 18, "R5 new cell kept");
        wait_dev(2);
        check(rd_rdy[0] == 1'b0, "R5 partial discarded", rd_rdy[0], 0);
    endtask

    // R7 R9
    task automatic t_full();
        logic cl;
        for (int n = 0; n < 4; n++) begin
            poll(5'd1, cl);
            check(cl == 1'b1, "R7 clav with room", cl, 1);
            send(5'd1, 20 + n, 0, 52, 1'b1);
        end
        poll(5'd1, cl);
        check(cl == 1'b0, "R7 clav low when full", cl, 0);
        send(5'd1, 30, 0, 52, 1'b1);
        wait_dev(10);
        check(err_flag[1] == 1'b1, "R7 overflow flagged", err_flag[1], 1);
        for (int n = 0; n < 4; n++) read_cell(1, 20 + n, "R7 R9 cells in order");
        wait_dev(2);
        check(rd_rdy[1] == 1'b0, "R7 extra cell dropped", rd_rdy[1], 0);
        repeat (10) @(negedge tx_clk);
        poll(5'd1, cl);
        check(cl == 1'b1, "R1 clav back after drain", cl, 1);
        idle();
    endtask

    initial begin
        repeat (5) @(negedge tx_clk);
        @(negedge tx_clk);
        t_reset();
        tx_rst_n = 1'b1;
        dev_rst_n = 1'b1;
        repeat (3) @(negedge tx_clk);
        t_poll();
        t_basic();
        t_unmatched();
        t_stray();
        t_partial();
        t_pop_empty();
        t_mid_soc();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tx_clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule